// File: doc/BRIEF.md
# Wide Multiply-Accumulate Register Unit

This unit serves a 64-bit core that does multi-precision integer arithmetic. It keeps hidden state: three multiplier words M0..M2, which together form a 192-bit multiplicand, and three partial-product words P0..P2, which together form a 192-bit carry-in. The core sends a command as a 6-bit function code with two 64-bit operands, `op_a` and `op_b`. Move commands load a single state word. Multiply commands return one 64-bit result word and update the hidden state. Because of this state, a sequence of triple-word multiplies computes a 192x64-bit multiply-accumulate, and the carry passes from one call to the next.

One 64x64 multiplier does the work. The unit uses it for one cycle per multiplier word, so a single-word command takes one step and a triple-word command takes three. While a multiply runs, `busy` is high. When the result is ready, `done` pulses for one cycle. The unit drops any command that arrives while it is busy.

Top module: `wide_mac_unit`

## Requirements
- R1: After reset, `busy`, `done` and `result` are zero, and all six state words read as zero.
- R2: Codes 0x08, 0x0C and 0x0D load `op_a` into M0, M1 and M2 respectively. Any of these loads also sets P0, P1 and P2 to zero.
- R3: Codes 0x09, 0x0A and 0x0B load `op_a` into P0, P1 and P2 respectively. No other state word changes.
- R4: Code 0x0F forms M0*op_a + op_b + P0 as a 128-bit value, returns bits 63:0 and writes bits 127:64 to P0. M0..M2, P1 and P2 are left unchanged.
- R5: Code 0x11 forms {M2,M1,M0}*op_a + op_b + {P2,P1,P0} as a 256-bit value and returns bits 63:0. It writes bits 127:64 to P0, bits 191:128 to P1 and bits 255:192 to P2.
- R6: Code 0x10 returns the low 64 bits of M0*op_a + op_b + P0. It writes that same value into M0 and sets P0..P2 to zero.
- R7: All operands are unsigned, and every carry out of a 64-bit word reaches the word above it. This holds even when every operand and state word is all ones.
- R8: Suppose a multiply is accepted at clock edge E. Then `busy` is high from E until the edge that finishes it, and `done` is high for exactly one cycle after that edge. The finishing edge is E+1 for codes 0x0F and 0x10, and E+3 for code 0x11. Move commands finish at E and raise neither `busy` nor `done`.
- R9: While `busy` is high, the unit ignores any command presented. An unknown function code has no effect on the state and starts nothing.
- R10: A command presented in the cycle where `done` is high is accepted, and it sees the state that the finished multiply wrote.
- R11: Three chained 0x11 commands give the same results and leave the same P words as plain 256-bit arithmetic on the 192-bit state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; the unit takes it when `busy` is low |
| cmd_func | input | 6 | Function code |
| op_a | input | 64 | First operand: the multiplier input, or the value to load |
| op_b | input | 64 | Second operand: the addend for multiplies |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse when `result` becomes valid |
| result | output | 64 | Low result word of the last finished multiply |

## Verification
Two things can happen in the same cycle: a multiply writes its state at its last edge, and the next command is presented. The bench provokes this by raising `cmd_valid` in the very cycle where `done` is high. It expects the new command to use the P words, or the M0 word, that the previous multiply has just written. A second clash is a command that arrives during a running triple-word multiply. The bench holds a move to M0 on the inputs while `busy` is high. It then judges by the running multiply's latency and by later results that the move never reached the state.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

  localparam int FUNC_W = 6;

  // Function codes the instruction decoder delivers
  localparam logic [FUNC_W-1:0] FN_LD_M0 = 6'h08;
  localparam logic [FUNC_W-1:0] FN_LD_M1 = 6'h0C;
  localparam logic [FUNC_W-1:0] FN_LD_M2 = 6'h0D;
  localparam logic [FUNC_W-1:0] FN_LD_P0 = 6'h09;
  localparam logic [FUNC_W-1:0] FN_LD_P1 = 6'h0A;
  localparam logic [FUNC_W-1:0] FN_LD_P2 = 6'h0B;
  localparam logic [FUNC_W-1:0] FN_MUL1  = 6'h0F;
  localparam logic [FUNC_W-1:0] FN_MULM  = 6'h10;
  localparam logic [FUNC_W-1:0] FN_MUL3  = 6'h11;

  typedef enum logic [2:0] {
    K_NONE,
    K_LD_M,
    K_LD_P,
    K_MUL1,
    K_MUL3,
    K_MULM
  } cmd_kind_e;

endpackage

// File: rtl/wmac_decode.sv
module wmac_decode
  import wmac_pkg::*;
#(
  parameter int NWORDS = 3,
  parameter int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic [FUNC_W-1:0] func,
  output cmd_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);

  int sel;
  cmd_kind_e raw;

  always_comb begin
    raw = K_NONE;
    sel = 0;
    case (func)
      FN_LD_M0: begin raw = K_LD_M; sel = 0; end
      FN_LD_M1: begin raw = K_LD_M; sel = 1; end
      FN_LD_M2: begin raw = K_LD_M; sel = 2; end
      FN_LD_P0: begin raw = K_LD_P; sel = 0; end
      FN_LD_P1: begin raw = K_LD_P; sel = 1; end
      FN_LD_P2: begin raw = K_LD_P; sel = 2; end
      FN_MUL1:  raw = K_MUL1;
      FN_MULM:  raw = K_MULM;
      FN_MUL3:  raw = K_MUL3;
      default:  raw = K_NONE;
    endcase
  end

  // loads that name a word beyond NWORDS are dropped like unknown codes
  always_comb begin
    kind = raw;
    if ((raw == K_LD_M || raw == K_LD_P) && sel >= NWORDS) kind = K_NONE;
  end

  assign idx = IDX_W'(sel);

endmodule

// File: rtl/wmac_regbank.sv
module wmac_regbank
  import wmac_pkg::*;
#(
  parameter int W      = 64,
  parameter int NWORDS = 3,
  parameter int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mv_we,
  input  logic                  mv_is_p,
  input  logic [IDX_W-1:0]      mv_idx,
  input  logic [W-1:0]          mv_data,
  input  logic                  fin_we,
  input  cmd_kind_e             fin_kind,
  input  logic [W*(NWORDS+1)-1:0] fin_acc,
  output logic [NWORDS*W-1:0]   m_flat,
  output logic [NWORDS*W-1:0]   p_flat
);

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic [W-1:0] m_r;
    logic [W-1:0] p_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_r <= '0;
      end else if (mv_we && !mv_is_p && mv_idx == MY_IDX) begin
        m_r <= mv_data;
      end else if (fin_we && fin_kind == K_MULM && i == 0) begin
        m_r <= fin_acc[W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_r <= '0;
      end else if (mv_we) begin
        if (!mv_is_p)               p_r <= '0;
        else if (mv_idx == MY_IDX)  p_r <= mv_data;
      end else if (fin_we) begin
        case (fin_kind)
          K_MUL1:  if (i == 0) p_r <= fin_acc[2*W-1:W];
          K_MUL3:  p_r <= fin_acc[(i+1)*W +: W];
          K_MULM:  p_r <= '0;
          default: ;
        endcase
      end
    end

    assign m_flat[i*W +: W] = m_r;
    assign p_flat[i*W +: W] = p_r;
  end

  // R2
  // a multiplier load leaves every partial word at zero
  m_load_clears_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_we && !mv_is_p) |=> (p_flat == '0));

  // R3
  // a partial load never disturbs the multiplier words
  p_load_keeps_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_we && mv_is_p) |=> (m_flat == $past(m_flat)));

  // R6
  // multiply-to-M0 writes its low word into M0 and empties P
  mulm_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_we && fin_kind == K_MULM) |=>
      ((p_flat == '0) && (m_flat[W-1:0] == $past(fin_acc[W-1:0]))));

endmodule

// File: rtl/wmac_engine.sv
module wmac_engine
  import wmac_pkg::*;
#(
  parameter int W      = 64,
  parameter int NWORDS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  cmd_kind_e               start_kind,
  input  logic [W-1:0]            opa,
  input  logic [W-1:0]            opb,
  input  logic [NWORDS*W-1:0]     m_flat,
  input  logic [NWORDS*W-1:0]     p_flat,
  output logic                    busy,
  output logic                    done,
  output logic [W-1:0]            result,
  output logic                    fin_we,
  output cmd_kind_e               fin_kind,
  output logic [W*(NWORDS+1)-1:0] fin_acc
);

  localparam int ACC_W  = W * (NWORDS + 1);
  localparam int STEP_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [STEP_W-1:0] LAST_WIDE = STEP_W'(NWORDS - 1);

  // starting accumulator: addend plus the partial words the op consumes
  function automatic logic [ACC_W-1:0] seed_acc(input cmd_kind_e k,
                                                input logic [NWORDS*W-1:0] p,
                                                input logic [W-1:0] addend);
    logic [ACC_W-1:0] base;
    if (k == K_MUL3) base = ACC_W'(p);
    else             base = ACC_W'(p[W-1:0]);
    return base + ACC_W'(addend);
  endfunction

  // one iteration: add one word product at its word position
  function automatic logic [ACC_W-1:0] add_partial(input logic [ACC_W-1:0] acc,
                                                   input logic [W-1:0] mword,
                                                   input logic [W-1:0] mult,
                                                   input logic [STEP_W-1:0] pos);
    logic [2*W-1:0] prod;
    prod = mword * mult;
    return acc + (ACC_W'(prod) << (W * int'(pos)));
  endfunction

  logic              busy_q, done_q;
  logic [W-1:0]      result_q, a_q;
  logic [ACC_W-1:0]  acc_q, acc_n;
  logic [STEP_W-1:0] step_q, last_q;
  cmd_kind_e         kind_q;
  logic [W-1:0]      m_sel;
  logic              at_last;

  assign m_sel   = m_flat[int'(step_q)*W +: W];
  assign acc_n   = add_partial(acc_q, m_sel, a_q, step_q);
  assign at_last = (step_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
      a_q      <= '0;
      acc_q    <= '0;
      step_q   <= '0;
      last_q   <= '0;
      kind_q   <= K_NONE;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        kind_q <= start_kind;
        a_q    <= opa;
        acc_q  <= seed_acc(start_kind, p_flat, opb);
        step_q <= '0;
        last_q <= (start_kind == K_MUL3) ? LAST_WIDE : '0;
      end else if (busy_q) begin
        acc_q <= acc_n;
        if (at_last) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= acc_n[W-1:0];
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign result   = result_q;
  assign fin_we   = busy_q && at_last;
  assign fin_kind = kind_q;
  assign fin_acc  = acc_n;

  // R8
  // done lasts a single cycle
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  // an accepted multiply is busy on the following cycle and not yet done
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R8
  // the finishing edge drops busy and raises done together
  finish_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_we |=> (done && !busy));

endmodule

// File: rtl/wide_mac_unit.sv
module wide_mac_unit
  import wmac_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int NWORDS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [5:0]        cmd_func,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result
);

  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int ACC_W = WORD_W * (NWORDS + 1);

  cmd_kind_e                kind;
  logic [IDX_W-1:0]         idx;
  logic                     accept, mv_we, mv_is_p, mul_start;
  logic                     fin_we;
  cmd_kind_e                fin_kind;
  logic [ACC_W-1:0]         fin_acc;
  logic [NWORDS*WORD_W-1:0] m_flat, p_flat;

  wmac_decode #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_decode (
    .func (cmd_func),
    .kind (kind),
    .idx  (idx)
  );

  // named command events
  assign accept    = cmd_valid && !busy;
  assign mv_we     = accept && (kind == K_LD_M || kind == K_LD_P);
  assign mv_is_p   = (kind == K_LD_P);
  assign mul_start = accept && (kind == K_MUL1 || kind == K_MUL3 || kind == K_MULM);

  wmac_regbank #(.W(WORD_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .mv_we    (mv_we),
    .mv_is_p  (mv_is_p),
    .mv_idx   (idx),
    .mv_data  (op_a),
    .fin_we   (fin_we),
    .fin_kind (fin_kind),
    .fin_acc  (fin_acc),
    .m_flat   (m_flat),
    .p_flat   (p_flat)
  );

  wmac_engine #(.W(WORD_W), .NWORDS(NWORDS)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (mul_start),
    .start_kind (kind),
    .opa        (op_a),
    .opb        (op_b),
    .m_flat     (m_flat),
    .p_flat     (p_flat),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .fin_we     (fin_we),
    .fin_kind   (fin_kind),
    .fin_acc    (fin_acc)
  );

  // R9
  // while a multiply runs and is not finishing, no state word moves
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_we) |=> ($stable(m_flat) && $stable(p_flat)));

  // R9
  // unknown codes start nothing
  unknown_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && kind == K_NONE) |=> !busy);

endmodule

// File: tb/tb_wide_mac_unit.sv
`timescale 1ns/1ps
module tb_wide_mac_unit;

  localparam logic [5:0] C_M0 = 6'h08, C_M1 = 6'h0C, C_M2 = 6'h0D;
  localparam logic [5:0] C_P0 = 6'h09, C_P1 = 6'h0A, C_P2 = 6'h0B;
  localparam logic [5:0] C_MUL1 = 6'h0F, C_MULM = 6'h10, C_MUL3 = 6'h11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [5:0]  cmd_func = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        busy, done;
  logic [63:0] result;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [63:0] bm [3];
  logic [63:0] bp [3];

  always #4 clk = ~clk;

  wide_mac_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] fn, input logic [63:0] a, input logic [63:0] b, input bit now);
    if (!now) @(negedge clk);
    cmd_valid = 1'b1; cmd_func = fn; op_a = a; op_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(inout int lat, output logic [63:0] res);
    while (!done && lat < 16) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  // requirement-level model of the multiplies (plain 256-bit arithmetic)
  task automatic model_mul(input logic [5:0] fn, input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] er, output int el);
    logic [255:0] s;
    if (fn == C_MUL3) begin
      s = {64'd0, bm[2], bm[1], bm[0]} * {192'd0, a} + {192'd0, b} + {64'd0, bp[2], bp[1], bp[0]};
      er = s[63:0]; bp[0] = s[127:64]; bp[1] = s[191:128]; bp[2] = s[255:192]; el = 3;
    end else begin
      s = {192'd0, bm[0]} * {192'd0, a} + {192'd0, b} + {192'd0, bp[0]};
      er = s[63:0]; el = 1;
      if (fn == C_MULM) begin
        bm[0] = s[63:0]; bp[0] = '0; bp[1] = '0; bp[2] = '0;
      end else begin
        bp[0] = s[127:64];
      end
    end
  endtask

  task automatic run_mul(input logic [5:0] fn, input logic [63:0] a, input logic [63:0] b,
                         input string tag, input bit now);
    logic [63:0] er, res;
    int el, lat;
    model_mul(fn, a, b, er, el);
    drive(fn, a, b, now);
    chk(busy === 1'b1, {tag, " busy after accept (R8)"}, 64'(busy), 64'd1);
    lat = 0;
    wait_done(lat, res);
    chk(res === er, {tag, " result"}, res, er);
    chk(lat == el, {tag, " latency (R8)"}, 64'(lat), 64'(el));
  endtask

  task automatic run_move(input logic [5:0] fn, input logic [63:0] a, input string tag);
    drive(fn, a, 64'h5a5a, 1'b0);
    case (fn)
      C_M0: begin bm[0] = a; bp[0] = '0; bp[1] = '0; bp[2] = '0; end
      C_M1: begin bm[1] = a; bp[0] = '0; bp[1] = '0; bp[2] = '0; end
      C_M2: begin bm[2] = a; bp[0] = '0; bp[1] = '0; bp[2] = '0; end
      C_P0: bp[0] = a;
      C_P1: bp[1] = a;
      C_P2: bp[2] = a;
      default: ;
    endcase
    chk(busy === 1'b0 && done === 1'b0, {tag, " move raises no busy/done (R8)"},
        {62'd0, busy, done}, 64'd0);
  endtask

  // reads P0,P1,P2 out in turn: rs=0, rt=0 triple multiplies shift the partials down
  task automatic read_p(input string tag);
    for (int k = 0; k < 3; k++) run_mul(C_MUL3, 64'd0, 64'd0, tag, 1'b0);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done after reset", {62'd0, busy, done}, 64'd0);
    chk(result === 64'd0, "R1 result after reset", result, 64'd0);
    read_p("R1 partials zero");
    run_mul(C_MUL1, 64'd5, 64'd7, "R1 M0 zero", 1'b0);
  endtask

  task automatic t_moves;
    run_move(C_M0, 64'h1111_2222_3333_4444, "R2 load M0");
    run_move(C_M1, 64'h0000_0000_0000_0003, "R2 load M1");
    run_move(C_M2, 64'h8000_0000_0000_0001, "R2 load M2");
    run_move(C_P0, 64'hAAAA, "R3 load P0");
    run_move(C_P1, 64'hBBBB, "R3 load P1");
    run_move(C_P2, 64'hCCCC, "R3 load P2");
    run_mul(C_MUL3, 64'd1, 64'd0, "R3 P load keeps M", 1'b0);
    read_p("R3 readout");
    run_move(C_P1, 64'h7777, "R3 load P1 alone");
    run_move(C_M1, 64'h0000_0000_0000_0005, "R2 load M1 clears P");
    read_p("R2 P cleared");
  endtask

  task automatic t_single;
    run_move(C_M0, 64'h0000_0001_0000_0000, "R4 set M0");
    run_move(C_P0, 64'h0000_0000_0000_0009, "R4 set P0");
    run_move(C_P2, 64'h1234, "R4 set P2");
    run_mul(C_MUL1, 64'h0000_0003_0000_0001, 64'h10, "R4 single a", 1'b0);
    run_mul(C_MUL1, 64'h0000_0000_0000_0002, 64'h0, "R4 single b uses new P0", 1'b0);
    read_p("R4 P1/P2 untouched");
  endtask

  task automatic t_triple;
    run_move(C_M0, 64'hDEAD_BEEF_0000_0001, "R5 set M0");
    run_move(C_M1, 64'h0123_4567_89AB_CDEF, "R5 set M1");
    run_move(C_M2, 64'hFEDC_BA98_7654_3210, "R5 set M2");
    run_move(C_P1, 64'h42, "R5 set P1");
    run_mul(C_MUL3, 64'h0F0F_0F0F_F0F0_F0F0, 64'h99, "R5 triple", 1'b0);
    read_p("R5 partials");
  endtask

  task automatic t_carry;
    run_move(C_M0, '1, "R7 M0 ones");
    run_move(C_M1, '1, "R7 M1 ones");
    run_move(C_M2, '1, "R7 M2 ones");
    run_move(C_P0, '1, "R7 P0 ones");
    run_move(C_P1, '1, "R7 P1 ones");
    run_move(C_P2, '1, "R7 P2 ones");
    run_mul(C_MUL3, '1, '1, "R7 triple all ones", 1'b0);
    run_move(C_P0, '1, "R7 P0 ones again");
    run_mul(C_MUL1, '1, '1, "R7 single all ones", 1'b0);
    read_p("R7 partial carries");
  endtask

  task automatic t_mulm;
    run_move(C_M0, 64'h0000_0000_1000_0001, "R6 set M0");
    run_move(C_P0, 64'h55, "R6 set P0");
    run_move(C_P2, 64'h66, "R6 set P2");
    run_mul(C_MULM, 64'h0000_0001_0000_0003, 64'h7, "R6 multiply-to-M0", 1'b0);
    run_mul(C_MUL1, 64'd1, 64'd0, "R6 M0 holds result", 1'b0);
    read_p("R6 partials");
  endtask

  task automatic t_busy_ignore;
    logic [63:0] er, res;
    int el, lat;
    run_move(C_M0, 64'h3, "R9 set M0");
    model_mul(C_MUL3, 64'h10, 64'h1, er, el);
    drive(C_MUL3, 64'h10, 64'h1, 1'b0);
    chk(busy === 1'b1, "R9 busy during triple", 64'(busy), 64'd1);
    cmd_valid = 1'b1; cmd_func = C_M0; op_a = 64'hBAD0_BAD0; op_b = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    wait_done(lat, res);
    chk(res === er, "R9 triple result with command held", res, er);
    chk(lat == el, "R9 latency with command held", 64'(lat), 64'(el));
    run_mul(C_MUL1, 64'd1, 64'd0, "R9 M0 not overwritten", 1'b0);
    drive(6'h3F, 64'hFFFF, 64'h1, 1'b0);
    chk(busy === 1'b0 && done === 1'b0, "R9 unknown code starts nothing", {62'd0, busy, done}, 64'd0);
    drive(6'h0E, 64'hFFFF, 64'h1, 1'b0);
    run_mul(C_MUL1, 64'd1, 64'd0, "R9 unknown code left state", 1'b0);
  endtask

  task automatic t_back_to_back;
    run_move(C_M0, 64'hFFFF_FFFF_FFFF_FFF1, "R10 set M0");
    run_mul(C_MUL1, 64'hFFFF_0000_0000_0005, 64'h3, "R10 first", 1'b0);
    run_mul(C_MUL1, 64'h7, 64'h0, "R10 second in done cycle", 1'b1);
    run_mul(C_MULM, 64'h2, 64'h1, "R10 mulm", 1'b0);
    run_mul(C_MUL1, 64'h3, 64'h0, "R10 sees new M0", 1'b1);
    run_mul(C_MUL3, 64'h9, 64'h4, "R10 triple", 1'b1);
  endtask

  task automatic t_chain;
    run_move(C_M0, 64'hC3C3_5A5A_0F0F_F00F, "R11 set M0");
    run_move(C_M1, 64'h8765_4321_FFFF_0001, "R11 set M1");
    run_move(C_M2, 64'hFFFF_FFFF_0000_0002, "R11 set M2");
    run_mul(C_MUL3, 64'hFEDC_0000_1111_2222, 64'hFFFF_FFFF_FFFF_FFFF, "R11 chain 1", 1'b0);
    run_mul(C_MUL3, 64'h1357_9BDF_2468_ACE0, 64'h0000_0000_0000_0123, "R11 chain 2", 1'b1);
    run_mul(C_MUL3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R11 chain 3", 1'b1);
    read_p("R11 final partials");
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin bm[k] = '0; bp[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_moves();
    t_single();
    t_triple();
    t_carry();
    t_mulm();
    t_busy_ignore();
    t_back_to_back();
    t_chain();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule